// File: doc/BRIEF.md
# Motion Estimation Row Processing Unit

This block is the arithmetic core of a block-matching motion estimator. Every clock it can take one row of a 16x16 template block (16 pixels) together with three rows of the search window: the row under the template, the row above it and the row below it. Each search row is 18 pixels wide, one extra column on each side. Sixteen identical lanes turn each pixel column into per-pixel terms. Adder trees fold the 16 lanes into one row sum per candidate, and accumulators add up the row sums of a whole macroblock.

A two-bit mode, captured on the start pulse, selects what the lanes compute. The options are the squared-error distortion, the horizontal or vertical gradient coefficient used for steepest-descent direction finding, or the distortion of all nine candidates of the 3x3 half-pel neighbourhood at once. A search controller pulses `start`, streams 16 rows with `row_valid` (bubbles allowed), and reads the results while `done` is high.

Window pixel j of every search row sits at bits [8j+7:8j]. Column j = 0 is one pixel left of the template's first column, so lane i uses window columns i (left), i+1 (centre) and i+2 (right). Template pixel i sits at bits [8i+7:8i].

Top module: `me_row_pu`

## Requirements
- R1: A job consists of exactly 16 rows. A row is taken on every clock edge where `row_valid` is high and the job has taken fewer than 16 rows. A row presented in the same cycle as `start` is the job's first row. Cycles with `row_valid` low are bubbles and change nothing.
- R2: Mode 2'b00 gives `cost` = sum over rows and lanes of (M[i+1] - T[i])^2. T is the template pixel and M is the centre search row.
- R3: Mode 2'b01 gives `cost` = sum of (M[i+1] - T[i]) * (M[i+2] - M[i]). The value is signed.
- R4: Mode 2'b10 gives `cost` = sum of (M[i+1] - T[i]) * (D[i+1] - U[i+1]). The value is signed. U is the row above and D is the row below.
- R5: Mode 2'b11 fills nine squared-error sums into `half_costs`. Slot k = 3*(dy+1) + (dx+1) occupies bits [26k+25:26k], with dx and dy in {-1,0,1} half-pel steps (negative is left/up).
  - A half-pel sample on a single axis is (a+b+1)>>1 of the centre and its neighbour on that axis.
  - A diagonal sample is (a+b+c+d+2)>>2 of the four surrounding integer pixels.
  - Slot 4 is the integer position, and `cost` equals slot 4.
- R6: In modes 2'b00, 2'b01 and 2'b10 every slot of `half_costs` except slot 4 reads zero.
- R7: `done` is high for exactly one cycle per completed job. It is the cycle after the second rising edge that follows the edge taking the 16th row. `cost` and `half_costs` hold the final values then and keep them until the next `start`.
- R8: Reset clears all results and `done`. A `start` clears all results on its edge and latches `mode`. A change of `mode` after the start edge has no effect on the running job.
- R9: Rows offered before any `start`, or after the 16th row of a job, are ignored. The results are unchanged and no extra `done` appears.
- R10: A `start` while a job is still taking or draining rows aborts that job. Its in-flight rows never reach the results and it produces no `done`.
- R11: Results are exact at full precision with no wrap. This holds at the extremes of ±255 pixel differences summed over 256 pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new job: clears results, latches mode |
| mode | input | 2 | Operation select, sampled with start |
| row_valid | input | 1 | A row is offered this cycle |
| tb_row | input | 128 | 16 template pixels of the current row |
| sw_up | input | 144 | 18 search pixels of the row above |
| sw_mid | input | 144 | 18 search pixels of the current row |
| sw_dn | input | 144 | 18 search pixels of the row below |
| done | output | 1 | One-cycle pulse: results final |
| cost | output | 26 | Signed result of the selected mode |
| half_costs | output | 234 | Nine 26-bit half-pel candidate sums |

## Verification
The interesting overlap is a `start` arriving in the same cycle that rows of an earlier job are still in the lane and tree registers, heading for the accumulators. The bench opens a job and feeds it a few rows. It then issues a new `start` together with the new job's first row, so a clear, a pending accumulate and a new row capture all meet on one edge. It judges the outcome by requiring exactly one `done` across both jobs and results equal to the second job's arithmetic alone. A second overlap is also covered: surplus rows arrive in the very cycles the final row drains. The bench checks that the results stay put after `done`.

// File: rtl/me_rpu_pkg.sv
package me_rpu_pkg;

    // Operation selected for a job; captured on the start pulse.
    typedef enum logic [1:0] {
        MODE_SSE   = 2'b00,
        MODE_GRADX = 2'b01,
        MODE_GRADY = 2'b10,
        MODE_HALF  = 2'b11
    } rpu_mode_e;

    // Candidates of the 3x3 half-pel neighbourhood, slot = 3*(dy+1)+(dx+1).
    localparam int NCAND       = 9;
    localparam int CAND_CENTRE = 4;

endpackage

// File: rtl/me_rpu_lane.sv
// One SIMD lane: turns one template pixel and a 3x3 patch of search pixels
// into NCAND signed terms, placed by candidate slot.
module me_rpu_lane
    import me_rpu_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int TW    = 2 * PIX_W + 2
) (
    input  rpu_mode_e           mode,
    input  logic [PIX_W-1:0]    tpix,
    input  logic [3*PIX_W-1:0]  up_px,
    input  logic [3*PIX_W-1:0]  mid_px,
    input  logic [3*PIX_W-1:0]  dn_px,
    output logic [NCAND*TW-1:0] terms
);

    localparam int DW = PIX_W + 2;
    localparam int PW = 2 * DW;

    typedef logic [PIX_W-1:0]     pix_t;
    typedef logic signed [DW-1:0] diff_t;
    typedef logic signed [TW-1:0] term_t;

    function automatic diff_t pdiff(input pix_t a, input pix_t b);
        return $signed({2'b00, a}) - $signed({2'b00, b});
    endfunction

    function automatic term_t mul(input diff_t a, input diff_t b);
        logic signed [PW-1:0] p;
        p = PW'(a) * PW'(b);
        return TW'(p);
    endfunction

    function automatic term_t sqd(input pix_t h, input pix_t t);
        diff_t d;
        d = pdiff(h, t);
        return mul(d, d);
    endfunction

    function automatic pix_t avg2(input pix_t a, input pix_t b);
        logic [DW-1:0] s;
        s = {2'b00, a} + {2'b00, b} + DW'(1);
        return pix_t'(s >> 1);
    endfunction

    function automatic pix_t avg4(input pix_t a, input pix_t b,
                                  input pix_t c, input pix_t d);
        logic [DW-1:0] s;
        s = {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d} + DW'(2);
        return pix_t'(s >> 2);
    endfunction

    pix_t  u0, u1, u2, m0, m1, m2, d0, d1, d2;
    diff_t dct, dgx, dgy;
    term_t term [NCAND];

    assign u0 = up_px[0*PIX_W +: PIX_W];
    assign u1 = up_px[1*PIX_W +: PIX_W];
    assign u2 = up_px[2*PIX_W +: PIX_W];
    assign m0 = mid_px[0*PIX_W +: PIX_W];
    assign m1 = mid_px[1*PIX_W +: PIX_W];
    assign m2 = mid_px[2*PIX_W +: PIX_W];
    assign d0 = dn_px[0*PIX_W +: PIX_W];
    assign d1 = dn_px[1*PIX_W +: PIX_W];
    assign d2 = dn_px[2*PIX_W +: PIX_W];

    always_comb begin
        for (int k = 0; k < NCAND; k++) begin
            term[k] = '0;
        end
        dct = pdiff(m1, tpix);
        dgx = pdiff(m2, m0);
        dgy = pdiff(d1, u1);
        case (mode)
            MODE_SSE:   term[CAND_CENTRE] = sqd(m1, tpix);
            MODE_GRADX: term[CAND_CENTRE] = mul(dct, dgx);
            MODE_GRADY: term[CAND_CENTRE] = mul(dct, dgy);
            MODE_HALF: begin
                term[0] = sqd(avg4(m1, m0, u1, u0), tpix);
                term[1] = sqd(avg2(m1, u1), tpix);
                term[2] = sqd(avg4(m1, m2, u1, u2), tpix);
                term[3] = sqd(avg2(m1, m0), tpix);
                term[4] = sqd(m1, tpix);
                term[5] = sqd(avg2(m1, m2), tpix);
                term[6] = sqd(avg4(m1, m0, d1, d0), tpix);
                term[7] = sqd(avg2(m1, d1), tpix);
                term[8] = sqd(avg4(m1, m2, d1, d2), tpix);
            end
            default: ;
        endcase
        for (int k = 0; k < NCAND; k++) begin
            terms[k*TW +: TW] = term[k];
        end
    end

endmodule

// File: rtl/me_rpu_sum_tree.sv
// Balanced binary adder tree over N signed leaves, built level by level.
module me_rpu_sum_tree #(
    parameter int N  = 16,
    parameter int IW = 18,
    parameter int OW = IW + $clog2(N)
) (
    input  logic [N*IW-1:0]     leaves,
    output logic signed [OW-1:0] total
);

    localparam int LV = $clog2(N);
    localparam int NP = 1 << LV;

    for (genvar lv = 0; lv <= LV; lv++) begin : g_lvl
        localparam int CNT = NP >> lv;
        logic signed [OW-1:0] s [CNT];
        if (lv == 0) begin : g_leaf
            for (genvar k = 0; k < CNT; k++) begin : g_k
                if (k < N) begin : g_real
                    assign s[k] = OW'($signed(leaves[k*IW +: IW]));
                end else begin : g_pad
                    assign s[k] = '0;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < CNT; k++) begin : g_k
                assign s[k] = g_lvl[lv-1].s[2*k] + g_lvl[lv-1].s[2*k+1];
            end
        end
    end

    assign total = g_lvl[LV].s[0];

endmodule

// File: rtl/me_row_pu.sv
// Row processing unit: lanes -> lane register -> adder trees -> tree
// register -> nine accumulators. Control and data share one state struct.
module me_row_pu
    import me_rpu_pkg::*;
#(
    parameter  int LANES = 16,
    parameter  int ROWS  = 16,
    parameter  int PIX_W = 8,
    localparam int WIN   = LANES + 2,
    localparam int TW    = 2 * PIX_W + 2,
    localparam int SUM_W = TW + $clog2(LANES),
    localparam int ACC_W = TW + $clog2(LANES * ROWS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               mode,
    input  logic                     row_valid,
    input  logic [LANES*PIX_W-1:0]   tb_row,
    input  logic [WIN*PIX_W-1:0]     sw_up,
    input  logic [WIN*PIX_W-1:0]     sw_mid,
    input  logic [WIN*PIX_W-1:0]     sw_dn,
    output logic                     done,
    output logic signed [ACC_W-1:0]  cost,
    output logic [NCAND*ACC_W-1:0]   half_costs
);

    localparam int CNT_W = $clog2(ROWS + 1);

    typedef struct packed {
        rpu_mode_e                       mode;
        logic [CNT_W-1:0]                rows;
        logic                            v1;
        logic                            last1;
        logic [NCAND-1:0][LANES*TW-1:0]  lanes;
        logic                            v2;
        logic                            last2;
        logic [NCAND-1:0][SUM_W-1:0]     sums;
        logic [NCAND-1:0][ACC_W-1:0]     accs;
        logic                            done;
    } rpu_state_t;

    rpu_state_t st_q, st_d;

    // ---------------- lane array ----------------
    rpu_mode_e                      run_mode;
    logic [NCAND*TW-1:0]            lane_out [LANES];
    logic [NCAND-1:0][LANES*TW-1:0] by_cand;

    assign run_mode = start ? rpu_mode_e'(mode) : st_q.mode;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        me_rpu_lane #(
            .PIX_W (PIX_W),
            .TW    (TW)
        ) u_lane (
            .mode   (run_mode),
            .tpix   (tb_row[i*PIX_W +: PIX_W]),
            .up_px  (sw_up[i*PIX_W +: 3*PIX_W]),
            .mid_px (sw_mid[i*PIX_W +: 3*PIX_W]),
            .dn_px  (sw_dn[i*PIX_W +: 3*PIX_W]),
            .terms  (lane_out[i])
        );
        for (genvar k = 0; k < NCAND; k++) begin : g_route
            assign by_cand[k][i*TW +: TW] = lane_out[i][k*TW +: TW];
        end
    end

    // ---------------- adder trees ----------------
    logic signed [SUM_W-1:0] tree_sum [NCAND];

    for (genvar k = 0; k < NCAND; k++) begin : g_tree
        me_rpu_sum_tree #(
            .N  (LANES),
            .IW (TW),
            .OW (SUM_W)
        ) u_tree (
            .leaves (st_q.lanes[k]),
            .total  (tree_sum[k])
        );
    end

    // ---------------- next state ----------------
    logic             take;
    logic [CNT_W-1:0] row_idx;

    always_comb begin
        st_d    = st_q;
        row_idx = start ? '0 : st_q.rows;
        take    = row_valid && (row_idx < CNT_W'(ROWS));

        st_d.v1    = take;
        st_d.last1 = take && (row_idx == CNT_W'(ROWS - 1));
        st_d.rows  = take ? row_idx + CNT_W'(1) : row_idx;
        if (take) begin
            st_d.lanes = by_cand;
        end

        if (start) begin
            st_d.mode  = rpu_mode_e'(mode);
            st_d.v2    = 1'b0;
            st_d.last2 = 1'b0;
            st_d.accs  = '0;
            st_d.done  = 1'b0;
        end else begin
            st_d.v2    = st_q.v1;
            st_d.last2 = st_q.last1;
            if (st_q.v1) begin
                for (int k = 0; k < NCAND; k++) begin
                    st_d.sums[k] = tree_sum[k];
                end
            end
            if (st_q.v2) begin
                for (int k = 0; k < NCAND; k++) begin
                    st_d.accs[k] = st_q.accs[k] + ACC_W'($signed(st_q.sums[k]));
                end
            end
            st_d.done = st_q.v2 && st_q.last2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rows <= CNT_W'(ROWS);
        end else begin
            st_q <= st_d;
        end
    end

    assign done       = st_q.done;
    assign cost       = $signed(st_q.accs[CAND_CENTRE]);
    assign half_costs = st_q.accs;

endmodule

// File: rtl/me_row_pu_chk.sv
module me_row_pu_chk #(
    parameter int ACC_W = 26,
    parameter int NCAND = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [1:0]              mode,
    input logic                    row_valid,
    input logic                    done,
    input logic signed [ACC_W-1:0] cost,
    input logic [NCAND*ACC_W-1:0]  half_costs
);

    localparam int TOTW = NCAND * ACC_W;
    localparam logic [TOTW-1:0] CMASK =
        {{(TOTW-ACC_W){1'b0}}, {ACC_W{1'b1}}} << (4 * ACC_W);

    logic [1:0] mode_l;
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_l <= 2'b00;
        else if (start) mode_l <= mode;
    end

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done only follows a row taken three samples earlier
    a_r7_done_after_row: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(row_valid, 3));

    // R8: start clears every result and suppresses done on the next cycle
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cost == '0) && (half_costs == '0) && !done);

    // R6: only the centre slot is used outside half-pel mode
    a_r6_side_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_l != 2'b11) |-> ((half_costs & ~CMASK) == '0));

    // R2: squared-error sums are never negative
    a_r2_sse_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_l == 2'b00 || mode_l == 2'b11) |-> !cost[ACC_W-1]);

endmodule

bind me_row_pu me_row_pu_chk #(
    .ACC_W (ACC_W),
    .NCAND (me_rpu_pkg::NCAND)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .row_valid  (row_valid),
    .done       (done),
    .cost       (cost),
    .half_costs (half_costs)
);

// File: tb/sim_me_row_pu.sv
module sim_me_row_pu;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int ROWS  = 16;
    localparam int PIX_W = 8;
    localparam int WIN   = LANES + 2;
    localparam int ACC_W = 2 * PIX_W + 2 + $clog2(LANES * ROWS);
    localparam int NC    = 9;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [1:0]              mode = 2'b00;
    logic                    row_valid = 1'b0;
    logic [LANES*PIX_W-1:0]  tb_row = '0;
    logic [WIN*PIX_W-1:0]    sw_up = '0;
    logic [WIN*PIX_W-1:0]    sw_mid = '0;
    logic [WIN*PIX_W-1:0]    sw_dn = '0;
    logic                    done;
    logic signed [ACC_W-1:0] cost;
    logic [NC*ACC_W-1:0]     half_costs;

    me_row_pu #(.LANES(LANES), .ROWS(ROWS), .PIX_W(PIX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .row_valid(row_valid), .tb_row(tb_row), .sw_up(sw_up),
        .sw_mid(sw_mid), .sw_dn(sw_dn), .done(done), .cost(cost),
        .half_costs(half_costs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int done_seen = 0;
    bit finished = 0;

    int tpx [ROWS][LANES];
    int upx [ROWS][WIN];
    int mpx [ROWS][WIN];
    int dpx [ROWS][WIN];
    longint expv [NC];

    always @(negedge clk) if (rst_n && done) done_seen++;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic longint half_val(input int k);
        return longint'($signed(half_costs[k*ACC_W +: ACC_W]));
    endfunction

    // 0 random, 1 tb=0/window=255, 2 tb=255 mid=0 up=0 dn=255, 3 ramp
    task automatic fill(input int pat);
        for (int r = 0; r < ROWS; r++) begin
            for (int j = 0; j < WIN; j++) begin
                case (pat)
                    1: begin upx[r][j] = 255; mpx[r][j] = 255; dpx[r][j] = 255; end
                    2: begin upx[r][j] = 0;   mpx[r][j] = 0;   dpx[r][j] = 255; end
                    3: begin upx[r][j] = (r*7 + j*3) % 256; mpx[r][j] = (r*5 + j*11) % 256;
                             dpx[r][j] = (r*13 + j*2) % 256; end
                    default: begin upx[r][j] = int'($urandom % 256); mpx[r][j] = int'($urandom % 256);
                                   dpx[r][j] = int'($urandom % 256); end
                endcase
            end
            for (int i = 0; i < LANES; i++) begin
                case (pat)
                    1: tpx[r][i] = 0;
                    2: tpx[r][i] = 255;
                    3: tpx[r][i] = (r*17 + i*9) % 256;
                    default: tpx[r][i] = int'($urandom % 256);
                endcase
            end
        end
    endtask

    task automatic calc(input int md);
        for (int k = 0; k < NC; k++) expv[k] = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int i = 0; i < LANES; i++) begin
                int t, c, l, rt, u, d, ul, ur, dl, dr;
                int h [NC];
                t = tpx[r][i]; c = mpx[r][i+1]; l = mpx[r][i]; rt = mpx[r][i+2];
                u = upx[r][i+1]; d = dpx[r][i+1];
                ul = upx[r][i]; ur = upx[r][i+2]; dl = dpx[r][i]; dr = dpx[r][i+2];
                case (md)
                    0: expv[4] += longint'((c - t) * (c - t));
                    1: expv[4] += longint'((c - t) * (rt - l));
                    2: expv[4] += longint'((c - t) * (d - u));
                    default: begin
                        h[0] = (c + l + u + ul + 2) / 4;
                        h[1] = (c + u + 1) / 2;
                        h[2] = (c + rt + u + ur + 2) / 4;
                        h[3] = (c + l + 1) / 2;
                        h[4] = c;
                        h[5] = (c + rt + 1) / 2;
                        h[6] = (c + l + d + dl + 2) / 4;
                        h[7] = (c + d + 1) / 2;
                        h[8] = (c + rt + d + dr + 2) / 4;
                        for (int k = 0; k < NC; k++)
                            expv[k] += longint'((h[k] - t) * (h[k] - t));
                    end
                endcase
            end
        end
    endtask

    task automatic drive_row(input int r);
        for (int i = 0; i < LANES; i++) tb_row[i*PIX_W +: PIX_W] = PIX_W'(tpx[r][i]);
        for (int j = 0; j < WIN; j++) begin
            sw_up[j*PIX_W +: PIX_W]  = PIX_W'(upx[r][j]);
            sw_mid[j*PIX_W +: PIX_W] = PIX_W'(mpx[r][j]);
            sw_dn[j*PIX_W +: PIX_W]  = PIX_W'(dpx[r][j]);
        end
    endtask

    task automatic drive_junk();
        tb_row = {(LANES*PIX_W){1'b1}};
        for (int j = 0; j < WIN; j++) begin
            sw_up[j*PIX_W +: PIX_W]  = PIX_W'(j * 13);
            sw_mid[j*PIX_W +: PIX_W] = PIX_W'(j * 29 + 7);
            sw_dn[j*PIX_W +: PIX_W]  = PIX_W'(j * 41);
        end
    endtask

    task automatic check_results(input int md, input bit ext);
        string tg;
        tg = (md == 0) ? "R2" : (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
        check(ext ? {tg, " R11 cost"} : {tg, " cost"}, longint'(cost), expv[4]);
        for (int k = 0; k < NC; k++) begin
            if (md == 3) check(ext ? "R5 R11 half slot" : "R5 half slot", half_val(k), expv[k]);
            else if (k != 4) check("R6 side slot zero", half_val(k), 0);
        end
    endtask

    // One job: start (optionally carrying row 0), rows with optional bubbles,
    // optional surplus rows after the 16th, then timing and value checks.
    task automatic run_job(input int md, input bit with_row, input bit gaps,
                           input int extra, input bit ext);
        int r, c, d0;
        calc(md);
        d0 = done_seen;
        @(negedge clk);
        start = 1'b1;
        mode = 2'(md);
        if (with_row) begin drive_row(0); row_valid = 1'b1; r = 1; end
        else begin row_valid = 1'b0; r = 0; end
        c = 0;
        while (r < ROWS) begin
            @(negedge clk);
            start = 1'b0;
            mode = 2'(md ^ 3);
            if (gaps && (c % 3 == 1)) row_valid = 1'b0;
            else begin drive_row(r); row_valid = 1'b1; r++; end
            c++;
        end
        @(negedge clk);
        start = 1'b0;
        if (extra > 0) begin drive_junk(); row_valid = 1'b1; end else row_valid = 1'b0;
        check("R7 done low +1", longint'(done), 0);
        @(negedge clk);
        check("R7 done low +2", longint'(done), 0);
        @(negedge clk);
        check("R7 done high", longint'(done), 1);
        check_results(md, ext);
        @(negedge clk);
        row_valid = 1'b0;
        check("R7 done single", longint'(done), 0);
        check(extra > 0 ? "R9 surplus rows ignored" : "R7 result held", longint'(cost), expv[4]);
        @(negedge clk);
        check("R7 one done per job", longint'(done_seen - d0), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check("R8 reset done", longint'(done), 0);
        check("R8 reset cost", longint'(cost), 0);
        for (int k = 0; k < NC; k++) check("R8 reset half slot", half_val(k), 0);

        // R9: rows before any start are ignored
        fill(0);
        for (int r = 0; r < 5; r++) begin
            drive_row(r); row_valid = 1'b1;
            @(negedge clk);
        end
        row_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 idle rows cost", longint'(cost), 0);
        check("R9 idle rows done", longint'(done_seen), 0);

        // R1-style sweep over modes, start alignment, bubbles and surplus rows
        for (int md = 0; md < 4; md++) begin
            for (int pat = 0; pat < 4; pat++) begin
                fill(pat);
                run_job(md, pat[0], pat >= 2, (pat == 3) ? 3 : 0, pat == 1 || pat == 2);
            end
        end
        for (int n = 0; n < 8; n++) begin
            fill(0);
            run_job(n % 4, n[1], n[0], n % 3, 1'b0);
        end

        // R8: start without rows clears results immediately
        @(negedge clk);
        start = 1'b1; mode = 2'b11; row_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R8 start clears cost", longint'(cost), 0);
        for (int k = 0; k < NC; k++) check("R8 start clears half", half_val(k), 0);

        // R10: abort a job with rows in flight; new start carries its row 0
        begin
            int d_before;
            d_before = done_seen;
            fill(0);
            @(negedge clk);
            start = 1'b1; mode = 2'b01; drive_row(0); row_valid = 1'b1;
            for (int r = 1; r < 7; r++) begin
                @(negedge clk);
                start = 1'b0; drive_row(r);
            end
            fill(3);
            run_job(0, 1'b1, 1'b0, 0, 1'b0);
            check("R10 aborted job gives no done", longint'(done_seen - d_before), 1);
            check("R10 result of new job only", longint'(cost), expv[4]);
        end

        // R1: bubble-heavy job in half-pel mode
        fill(0);
        run_job(3, 1'b0, 1'b1, 2, 1'b0);

        repeat (2) @(negedge clk);
        summary();
    end

endmodule